// File: doc/BRIEF.md
# Crypto Descriptor Fetch Channel

This block sequences jobs for a descriptor-driven crypto accelerator. Software pushes descriptor addresses into a small first-in first-out queue. The channel takes the entry at the head of the queue. A non-zero entry makes the channel issue one burst read of eight 64-bit words over a ready/valid memory read port. The channel then decodes the first word as the job header and the other seven words as pointer entries. It offers the decoded job to an execution-unit port and waits for the unit to report completion. After that it returns to the queue for the next entry.

Word 0, the header, is passed to the execution unit unchanged. Its bit 0 asks for a completion interrupt. The seven pointer words share one layout: bits [31:0] hold the address, bits [35:32] extend it to 36 bits, bits [39:36] are reserved, bits [47:40] carry the extent and bits [63:48] carry the length. A zero queue entry is dropped and no read is issued for it. A read error during a fetch stops the channel in a halted state until software clears it.

The controller has six states:
- IDLE: waits on the queue.
- FETCH_REQ: holds the read request.
- FETCH_BEAT: collects the eight beats.
- OFFER: holds the job valid.
- BUSY: waits for completion.
- HALT: parked after an error.

It has these transitions:
- IDLE to FETCH_REQ when the head entry is non-zero. A zero head entry is popped and the channel stays in IDLE.
- FETCH_REQ to FETCH_BEAT when the read is acknowledged.
- FETCH_BEAT to OFFER on the eighth clean beat.
- FETCH_BEAT to HALT on a beat that carries an error.
- OFFER to BUSY on job ready.
- BUSY to IDLE on unit done.
- HALT to IDLE on error clear.

Top module: `dsc_chan`

## Requirements
- R1: The queue holds 8 addresses. `push_full` is high exactly when 8 are stored. A push made while `push_full` is high is dropped and its address is never fetched.
- R2: For a non-zero address, `rd_req` rises with `rd_addr` equal to that address. Both stay unchanged until `rd_ack`. Exactly eight `rd_vld` beats are then taken, and `job_valid` is high in the cycle after the eighth beat.
- R3: `job_hdr` equals descriptor word 0 while `job_valid` is high.
- R4: For pointer entry k (descriptor word k+1, k = 0..6), `job_ptr[k*36 +: 36]` equals word bits [35:0]. `job_ext[k*8 +: 8]` equals bits [47:40]. `job_len[k*16 +: 16]` equals bits [63:48].
- R5: `job_valid` and `job_hdr` stay unchanged until `job_ready`. No new read is requested before `eu_done` ends the current job.
- R6: `done_irq` is a one-cycle pulse in the cycle after `eu_done`. It occurs only when bit 0 of the job header is 1.
- R7: `last_addr` takes the address of the completed descriptor in the cycle after `eu_done`, whatever the notify bit.
- R8: A zero address at the head of the queue is discarded without any read request. The channel stays idle until a non-zero address arrives.
- R9: A beat with `rd_err` high aborts the job: no job is offered, and `err_flag` rises in the next cycle. It then stays high, with `rd_req` low, until `err_clr`. The channel then resumes with the next queued address.
- R10: After reset, `rd_req`, `job_valid`, `push_full`, `err_flag` and `done_irq` are 0 and `last_addr` is 0.
- R11: Descriptors are fetched in the order their addresses were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Host offers a descriptor address |
| push_addr | input | 36 | Descriptor address offered |
| push_full | output | 1 | Queue full; pushes are dropped |
| rd_req | output | 1 | Burst read request |
| rd_addr | output | 36 | Burst read start address |
| rd_ack | input | 1 | Read request accepted |
| rd_vld | input | 1 | Read data beat valid |
| rd_data | input | 64 | Read data beat |
| rd_err | input | 1 | Error on this beat |
| job_valid | output | 1 | Decoded job offered |
| job_ready | input | 1 | Execution unit takes the job |
| job_hdr | output | 64 | Job header word |
| job_len | output | 112 | Seven 16-bit lengths |
| job_ext | output | 56 | Seven 8-bit extents |
| job_ptr | output | 252 | Seven 36-bit pointers |
| eu_done | input | 1 | Execution unit finished the job |
| done_irq | output | 1 | Completion interrupt pulse |
| last_addr | output | 36 | Address of the last completed descriptor |
| err_flag | output | 1 | Channel halted on a read error |
| err_clr | input | 1 | Clear the error and resume |

## Verification
Random runs mix address streams with random gaps in pushes, acknowledges, beats, job acceptance and completion. The header notify bit follows an address bit, so both interrupt outcomes occur, and each decoded field comes from the address. A field swapped between entries or taken from a shifted slice therefore shows up as a mismatch. Directed cases show zero-entry skipping apart from an ordinary idle period. A stalled unit is used to fill the queue and check that the overflow push never reaches memory. An error beat in the middle of a burst shows that the aborted job is never offered and that the queue entry after it still runs.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
    localparam int WORD_W     = 64;
    localparam int DESC_WORDS = 8;
    localparam int NUM_PTR    = DESC_WORDS - 1;
    localparam int LEN_W      = 16;
    localparam int LEN_LSB    = 48;
    localparam int EXT_W      = 8;
    localparam int EXT_LSB    = 40;
    localparam int NOTIFY_BIT = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_REQ,
        ST_FETCH_BEAT,
        ST_OFFER,
        ST_BUSY,
        ST_HALT
    } chan_state_t;
endpackage

// File: rtl/dsc_addr_fifo.sv
module dsc_addr_fifo #(
    parameter int AW    = 36,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_data,
    output logic          full,
    input  logic          rd_en,
    output logic          empty,
    output logic [AW-1:0] head
);
    // DEPTH must be a power of two so the pointers wrap naturally.
    localparam int PW = $clog2(DEPTH);

    logic [AW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [PW:0]   count;
    logic          do_wr, do_rd;

    assign full  = (count == (PW+1)'(DEPTH));
    assign empty = (count == '0);
    assign head  = mem[rd_ptr];
    assign do_wr = wr_en && !full;
    assign do_rd = rd_en && !empty;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) begin
                mem[wr_ptr] <= wr_data;
                wr_ptr      <= wr_ptr + 1'b1;
            end
            if (do_rd) rd_ptr <= rd_ptr + 1'b1;
            if (do_wr && !do_rd)      count <= count + 1'b1;
            else if (!do_wr && do_rd) count <= count - 1'b1;
        end
    end

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_en) |=> (full && count == $past(count)));
endmodule

// File: rtl/dsc_ptr_decode.sv
module dsc_ptr_decode
    import dsc_pkg::*;
#(
    parameter int PTR_W = 36
) (
    input  logic [WORD_W-1:0] word,
    output logic [LEN_W-1:0]  len,
    output logic [EXT_W-1:0]  ext,
    output logic [PTR_W-1:0]  ptr
);
    // PTR_W is 32 or 36; bits above it up to the extent are reserved.
    assign len = word[LEN_LSB +: LEN_W];
    assign ext = word[EXT_LSB +: EXT_W];
    assign ptr = word[PTR_W-1:0];

    logic unused_rsvd;
    assign unused_rsvd = ^word[EXT_LSB-1:PTR_W];
endmodule

// File: rtl/dsc_chan.sv
module dsc_chan
    import dsc_pkg::*;
#(
    parameter int ADDR_W     = 36,
    parameter int PTR_W      = 36,
    parameter int FIFO_DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push_valid,
    input  logic [ADDR_W-1:0]        push_addr,
    output logic                     push_full,
    output logic                     rd_req,
    output logic [ADDR_W-1:0]        rd_addr,
    input  logic                     rd_ack,
    input  logic                     rd_vld,
    input  logic [WORD_W-1:0]        rd_data,
    input  logic                     rd_err,
    output logic                     job_valid,
    input  logic                     job_ready,
    output logic [WORD_W-1:0]        job_hdr,
    output logic [NUM_PTR*LEN_W-1:0] job_len,
    output logic [NUM_PTR*EXT_W-1:0] job_ext,
    output logic [NUM_PTR*PTR_W-1:0] job_ptr,
    input  logic                     eu_done,
    output logic                     done_irq,
    output logic [ADDR_W-1:0]        last_addr,
    output logic                     err_flag,
    input  logic                     err_clr
);
    localparam int BEAT_W = $clog2(DESC_WORDS);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(DESC_WORDS - 1);

    chan_state_t       state, nxt;
    logic              fifo_empty, fifo_pop;
    logic [ADDR_W-1:0] fifo_head;
    logic [ADDR_W-1:0] cur_addr;
    logic [BEAT_W-1:0] beat_cnt;
    logic [WORD_W-1:0] words [DESC_WORDS];
    logic              head_zero;

    dsc_addr_fifo #(.AW(ADDR_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push_valid),
        .wr_data (push_addr),
        .full    (push_full),
        .rd_en   (fifo_pop),
        .empty   (fifo_empty),
        .head    (fifo_head)
    );

    assign head_zero = (fifo_head == '0);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:       if (!fifo_empty && !head_zero) nxt = ST_FETCH_REQ;
            ST_FETCH_REQ:  if (rd_ack) nxt = ST_FETCH_BEAT;
            ST_FETCH_BEAT: if (rd_vld) begin
                               if (rd_err)                    nxt = ST_HALT;
                               else if (beat_cnt == LAST_BEAT) nxt = ST_OFFER;
                           end
            ST_OFFER:      if (job_ready) nxt = ST_BUSY;
            ST_BUSY:       if (eu_done) nxt = ST_IDLE;
            ST_HALT:       if (err_clr) nxt = ST_IDLE;
            default:       nxt = ST_IDLE;
        endcase
    end

    // State-decoded outputs
    always_comb begin
        rd_req    = 1'b0;
        job_valid = 1'b0;
        err_flag  = 1'b0;
        fifo_pop  = 1'b0;
        unique case (state)
            ST_IDLE:       fifo_pop  = !fifo_empty;
            ST_FETCH_REQ:  rd_req    = 1'b1;
            ST_FETCH_BEAT: ;
            ST_OFFER:      job_valid = 1'b1;
            ST_BUSY:       ;
            ST_HALT:       err_flag  = 1'b1;
            default:       ;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            beat_cnt  <= '0;
            last_addr <= '0;
            done_irq  <= 1'b0;
            for (int i = 0; i < DESC_WORDS; i++) words[i] <= '0;
        end else begin
            done_irq <= 1'b0;
            if (state == ST_IDLE) begin
                beat_cnt <= '0;
                if (fifo_pop && !head_zero) cur_addr <= fifo_head;
            end
            if (state == ST_FETCH_BEAT && rd_vld && !rd_err) begin
                words[beat_cnt] <= rd_data;
                beat_cnt        <= beat_cnt + 1'b1;
            end
            if (state == ST_BUSY && eu_done) begin
                last_addr <= cur_addr;
                done_irq  <= words[0][NOTIFY_BIT];
            end
        end
    end

    assign rd_addr = cur_addr;
    assign job_hdr = words[0];

    for (genvar k = 0; k < NUM_PTR; k++) begin : g_dec
        dsc_ptr_decode #(.PTR_W(PTR_W)) u_dec (
            .word (words[k+1]),
            .len  (job_len[k*LEN_W +: LEN_W]),
            .ext  (job_ext[k*EXT_W +: EXT_W]),
            .ptr  (job_ptr[k*PTR_W +: PTR_W])
        );
    end

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));
    // R5
    job_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (job_valid && !job_ready) |=> (job_valid && $stable(job_hdr)));
    // R5
    one_job_chk: assert property (@(posedge clk) disable iff (!rst_n)
        job_valid |-> !rd_req);
    // R6
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);
    // R9
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> (err_flag && !rd_req));
endmodule

// File: tb/sim_dsc_chan.sv
`timescale 1ns/1ps
module sim_dsc_chan;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         push_valid = 1'b0;
    logic [35:0]  push_addr = '0;
    logic         push_full;
    logic         rd_req;
    logic [35:0]  rd_addr;
    logic         rd_ack = 1'b0, rd_vld = 1'b0, rd_err = 1'b0;
    logic [63:0]  rd_data = '0;
    logic         job_valid;
    logic         job_ready = 1'b0;
    logic [63:0]  job_hdr;
    logic [111:0] job_len;
    logic [55:0]  job_ext;
    logic [251:0] job_ptr;
    logic         eu_done = 1'b0;
    logic         done_irq;
    logic [35:0]  last_addr;
    logic         err_flag;
    logic         err_clr = 1'b0;

    always #4 clk = ~clk;

    dsc_chan u0 (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_addr(push_addr),
        .push_full(push_full), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
        .rd_vld(rd_vld), .rd_data(rd_data), .rd_err(rd_err), .job_valid(job_valid),
        .job_ready(job_ready), .job_hdr(job_hdr), .job_len(job_len), .job_ext(job_ext),
        .job_ptr(job_ptr), .eu_done(eu_done), .done_irq(done_irq), .last_addr(last_addr),
        .err_flag(err_flag), .err_clr(err_clr)
    );

    int          n_chk = 0, n_bad = 0;
    bit          finished = 1'b0;
    bit          eu_hold = 1'b0;
    bit          acc;
    logic [35:0] exp_q[$];
    logic [35:0] err_addr = '1;
    logic [35:0] m_a, e_a;
    logic [63:0] e_w;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] dword(input logic [35:0] a, input int i);
        logic [31:0] lo;
        lo = a[31:0];
        return {lo ^ (32'hC3A5_0000 + 32'(i) * 32'h0001_1111),
                (lo >> 3) ^ (32'(i) * 32'h2461_3579)};
    endfunction

    task automatic push(input logic [35:0] a, output bit accepted);
        @(negedge clk);
        push_valid = 1'b1;
        push_addr  = a;
        accepted   = !push_full;
        if (accepted && a != '0) exp_q.push_back(a);
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic drain();
        int guard = 0;
        while (exp_q.size() != 0 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (30) @(negedge clk);
    endtask

    // Memory responder
    always begin
        @(negedge clk);
        if (rd_req) begin
            m_a = rd_addr;
            if (exp_q.size() == 0) chk(1'b0, "R11 fetch with nothing queued", 64'(m_a), 64'(0));
            else chk(m_a == exp_q[0], "R11 fetch order", 64'(m_a), 64'(exp_q[0]));
            repeat ($urandom_range(0, 3)) begin
                @(negedge clk);
                chk(rd_req && rd_addr == m_a, "R2 request held", 64'(rd_addr), 64'(m_a));
            end
            rd_ack = 1'b1;
            @(negedge clk);
            rd_ack = 1'b0;
            for (int i = 0; i < 8; i++) begin
                repeat ($urandom_range(0, 2)) @(negedge clk);
                rd_vld  = 1'b1;
                rd_data = dword(m_a, i);
                rd_err  = (m_a == err_addr && i == 3);
                @(negedge clk);
                rd_vld = 1'b0;
                rd_err = 1'b0;
                if (m_a == err_addr && i == 3) begin
                    if (exp_q.size() != 0) void'(exp_q.pop_front());
                    break;
                end
                if (i == 7) chk(job_valid, "R2 job after eighth beat", 64'(job_valid), 64'(1));
            end
        end
    end

    // Execution-unit model
    always begin
        @(negedge clk);
        if (job_valid) begin
            e_a = (exp_q.size() != 0) ? exp_q[0] : '0;
            chk(exp_q.size() != 0, "R9 job offered without queued descriptor", 64'(exp_q.size()), 64'(1));
            chk(job_hdr == dword(e_a, 0), "R3 header", job_hdr, dword(e_a, 0));
            for (int k = 0; k < 7; k++) begin
                e_w = dword(e_a, k + 1);
                chk(job_ptr[k*36 +: 36] == e_w[35:0], "R4 pointer", 64'(job_ptr[k*36 +: 36]), 64'(e_w[35:0]));
                chk(job_ext[k*8 +: 8] == e_w[47:40], "R4 extent", 64'(job_ext[k*8 +: 8]), 64'(e_w[47:40]));
                chk(job_len[k*16 +: 16] == e_w[63:48], "R4 length", 64'(job_len[k*16 +: 16]), 64'(e_w[63:48]));
            end
            repeat ($urandom_range(0, 3)) begin
                @(negedge clk);
                chk(job_valid && job_hdr == dword(e_a, 0), "R5 offer held", job_hdr, dword(e_a, 0));
            end
            job_ready = 1'b1;
            @(negedge clk);
            job_ready = 1'b0;
            repeat ($urandom_range(0, 4)) begin
                @(negedge clk);
                chk(!rd_req, "R5 no fetch while busy", 64'(rd_req), 64'(0));
            end
            while (eu_hold) begin
                @(negedge clk);
                chk(!rd_req, "R5 no fetch while busy", 64'(rd_req), 64'(0));
            end
            eu_done = 1'b1;
            @(negedge clk);
            eu_done = 1'b0;
            chk(done_irq == e_a[3], "R6 interrupt follows notify bit", 64'(done_irq), 64'(e_a[3]));
            chk(last_addr == e_a, "R7 last completed address", 64'(last_addr), 64'(e_a));
            if (exp_q.size() != 0) void'(exp_q.pop_front());
            @(negedge clk);
            chk(!done_irq, "R6 single-cycle pulse", 64'(done_irq), 64'(0));
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10 reset values
        chk(!rd_req && !job_valid && !push_full, "R10 reset outputs",
            {61'd0, rd_req, job_valid, push_full}, 64'd0);
        chk(!err_flag && !done_irq && last_addr == '0, "R10 reset status",
            {26'd0, last_addr, err_flag, done_irq}, 64'd0);
        rst_n = 1'b1;

        // Directed: notify set and clear
        push(36'h0_0000_1008, acc);
        push(36'h3_1234_5670, acc);
        drain();

        // R8: zero entry skipped
        push('0, acc);
        repeat (12) begin
            @(negedge clk);
            chk(!rd_req, "R8 zero entry not fetched", 64'(rd_req), 64'(0));
        end
        push(36'h0_ABCD_0008, acc);
        drain();

        // R1: fill while the unit stalls
        eu_hold = 1'b1;
        push(36'h0_0000_2000, acc);
        repeat (45) @(negedge clk);
        for (int j = 0; j < 8; j++) begin
            chk(!push_full, "R1 not full yet", 64'(push_full), 64'(0));
            push(36'h1_0000_0000 + 36'(j) * 36'h108, acc);
        end
        chk(push_full, "R1 full at eight", 64'(push_full), 64'(1));
        push(36'h7_7777_7778, acc);
        chk(!acc, "R1 push dropped when full", 64'(acc), 64'(0));
        eu_hold = 1'b0;
        drain();

        // R9: error mid-burst
        err_addr = 36'h2_DEAD_BEE8;
        push(err_addr, acc);
        push(36'h0_0F0F_0F08, acc);
        for (int g = 0; g < 100 && !err_flag; g++) @(negedge clk);
        chk(err_flag, "R9 error flag set", 64'(err_flag), 64'(1));
        repeat (10) begin
            @(negedge clk);
            chk(err_flag && !rd_req && !job_valid, "R9 halted",
                {61'd0, err_flag, rd_req, job_valid}, 64'd4);
        end
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        chk(!err_flag, "R9 cleared", 64'(err_flag), 64'(0));
        drain();
        err_addr = '1;

        // Random stream
        for (int n = 0; n < 40; n++) begin
            logic [35:0] a;
            a = {4'($urandom), $urandom} & ~36'h7;
            if ($urandom_range(0, 7) == 0) a = '0;
            while (push_full) @(negedge clk);
            push(a, acc);
            repeat ($urandom_range(0, 12)) @(negedge clk);
        end
        drain();
        chk(exp_q.size() == 0, "R11 all queued descriptors completed", 64'(exp_q.size()), 64'(0));

        if (!finished) begin
            finished = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R2 actual=hung expected=progress");
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule